// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural register state of a 32-bit processor with seven operating modes. Software sees sixteen general registers at a time. It also sees a current status word and, in the five exception modes, a saved status word. A mode field in the current status word selects which physical copy backs each register index. Some indices are always shared. Some are replaced only in the fast-interrupt mode. The stack pointer and link register have a separate copy for each exception mode. The program counter is a single register common to every mode.

The datapath gets two combinational read ports and one write port with byte, half-word and word sizes. A dedicated link write loads the return address into the current mode's link register. Privileged code can raise a per-port flag to reach another mode's banked copies. Exception entry copies the current status into the entered mode's saved-status register and switches the mode, all in one clock edge.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register reads zero, `cpsr_out` reads 0x00000013 (Supervisor), and `spsr_out` reads zero.
- R2: Indices 0 to 7 address the same physical register in every mode.
- R3: Indices 8 to 12 have a private set of five copies in FIQ mode (mode code 10001). All other modes share one set.
- R4: Index 13 and index 14 each have a private copy in FIQ, IRQ, Supervisor, Abort and Undefined modes. User and System share one copy.
- R5: Index 15 is one program counter that is common to all modes.
- R6: Writes take effect at the rising clock edge. A read of the register being written in the same cycle returns the old value.
- R7: `wr_size` 00 replaces only bits 7:0 and 01 replaces only bits 15:0, keeping the upper bits. Codes 10 and 11 replace the whole word.
- R8: `link_en` writes `link_addr` into the current mode's index-14 copy. During that cycle the `wr_en` write is ignored.
- R9: `exc_en`, given an exception-mode code in `exc_mode`, copies `cpsr_out` into that mode's saved status. It also sets `cpsr_out[4:0]` to the code and keeps bits 31:5. Any other code is ignored.
- R10: `spsr_out` shows the current mode's saved status and reads zero in User, System and unknown modes. `spsr_wr_en` writes only in an exception mode.
- R11: A set `*_use_alt` flag maps that port through `alt_mode` instead of the current mode, but only in a privileged mode (any recognised mode other than User). Otherwise the current mode is used.
- R12: A `cpsr_wr_en` write in an unprivileged mode updates bits 31:5 and keeps the mode field bits 4:0.
- R13: Mode codes are 10000 User, 10001 FIQ, 10010 IRQ, 10011 Supervisor, 10111 Abort, 11011 Undefined and 11111 System. Any other code maps and is privileged like User.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_use_alt | input | 1 | Port A maps through `alt_mode` |
| rd_a_data | output | DATA_W | Port A read data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_use_alt | input | 1 | Port B maps through `alt_mode` |
| rd_b_data | output | DATA_W | Port B read data |
| alt_mode | input | 5 | Mode code used by ports with the alternate flag |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_use_alt | input | 1 | Write port maps through `alt_mode` |
| wr_size | input | 2 | 00 byte, 01 half-word, 10/11 word |
| wr_data | input | DATA_W | Write data |
| link_en | input | 1 | Load the current index-14 copy with `link_addr` |
| link_addr | input | DATA_W | Return address |
| cpsr_wr_en | input | 1 | Write the current status |
| cpsr_wr_data | input | DATA_W | New current status |
| spsr_wr_en | input | 1 | Write the current mode's saved status |
| spsr_wr_data | input | DATA_W | New saved status |
| exc_en | input | 1 | Exception entry |
| exc_mode | input | 5 | Mode entered by the exception |
| cpsr_out | output | DATA_W | Current status |
| spsr_out | output | DATA_W | Saved status of the current mode |

## Verification
The bench builds the block at its default 32-bit width with masked partial writes enabled. At that width, writes of bytes and half-words leave visible upper bits to compare against, and the status words keep bits above the mode field whose preservation can be checked. Mode changes are driven through the current-status write and through exception entry. This lets one run visit every bank: the unprivileged User mode, where the alternate-mode flags must have no effect, and an unrecognised mode code.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   localparam int MODE_W = 5;
   localparam int IDX_W  = 4;

   typedef enum logic [MODE_W-1:0] {
      M_USR = 5'b10000,
      M_FIQ = 5'b10001,
      M_IRQ = 5'b10010,
      M_SVC = 5'b10011,
      M_ABT = 5'b10111,
      M_UND = 5'b11011,
      M_SYS = 5'b11111
   } mode_e;

   typedef enum logic [2:0] {
      BK_USR = 3'd0,
      BK_FIQ = 3'd1,
      BK_IRQ = 3'd2,
      BK_SVC = 3'd3,
      BK_ABT = 3'd4,
      BK_UND = 3'd5
   } bank_e;

   localparam int NUM_BANKS   = 6;
   localparam int NUM_EXC     = NUM_BANKS - 1;
   localparam int LOW_CNT     = 8;
   localparam int HI_CNT      = 5;
   localparam int IDX_SP      = LOW_CNT + HI_CNT;
   localparam int IDX_LR      = IDX_SP + 1;
   localparam int IDX_PC      = IDX_LR + 1;
   localparam int HI_BASE     = LOW_CNT;
   localparam int FIQ_HI_BASE = HI_BASE + HI_CNT;
   localparam int SPLR_BASE   = FIQ_HI_BASE + HI_CNT;
   localparam int NUM_GP      = SPLR_BASE + 2 * NUM_BANKS;
   localparam int PC_SLOT     = NUM_GP;
   localparam int NUM_PHYS    = NUM_GP + 1;
   localparam int PHYS_W      = $clog2(NUM_PHYS);

   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
   localparam logic [1:0] SZ_WORD = 2'b10;

   function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
      case (m)
         M_FIQ:   return BK_FIQ;
         M_IRQ:   return BK_IRQ;
         M_SVC:   return BK_SVC;
         M_ABT:   return BK_ABT;
         M_UND:   return BK_UND;
         default: return BK_USR;
      endcase
   endfunction

   function automatic logic is_exc(input logic [MODE_W-1:0] m);
      return bank_of(m) != BK_USR;
   endfunction

   function automatic logic is_priv(input logic [MODE_W-1:0] m);
      return is_exc(m) || (m == M_SYS);
   endfunction

endpackage

// File: rtl/rb_map.sv
module rb_map
   import regbank_pkg::*;
#(
   parameter int ADDR_W = PHYS_W
) (
   input  logic [MODE_W-1:0] mode,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] phys
);

   initial begin
      addr_w_chk : assert (ADDR_W >= $clog2(NUM_PHYS))
         else $error("ADDR_W too small for physical slots");
   end

   bank_e bk;
   int    idx_i;
   int    slot;

   always_comb begin
      bk    = bank_of(mode);
      idx_i = int'(idx);
      if (idx_i < LOW_CNT) begin
         slot = idx_i;
      end else if (idx_i < IDX_SP) begin
         slot = ((bk == BK_FIQ) ? FIQ_HI_BASE : HI_BASE) + idx_i - LOW_CNT;
      end else if (idx_i == IDX_PC) begin
         slot = PC_SLOT;
      end else begin
         slot = SPLR_BASE + 2 * int'(bk) + idx_i - IDX_SP;
      end
      phys = ADDR_W'(slot);
   end

endmodule

// File: rtl/rb_gpr_array.sv
module rb_gpr_array
   import regbank_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = NUM_PHYS,
   parameter bit MASKED = 1'b1,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [1:0]        wsize,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_b
);

   initial begin
      width_chk : assert (DATA_W >= 16 && DATA_W % 8 == 0)
         else $error("DATA_W must be a multiple of 8 and at least 16");
   end

   logic [DATA_W-1:0] rows [DEPTH];
   logic [DATA_W-1:0] wmask;
   logic [DATA_W-1:0] old_row;
   logic [DATA_W-1:0] merged;

   generate
      if (MASKED) begin : g_masked
         always_comb begin
            case (wsize)
               SZ_BYTE: wmask = DATA_W'(8'hFF);
               SZ_HALF: wmask = DATA_W'(16'hFFFF);
               default: wmask = '1;
            endcase
         end
      end else begin : g_full
         always_comb wmask = '1;
      end
   endgenerate

   always_comb begin
      old_row = (int'(waddr) < DEPTH) ? rows[waddr] : '0;
      merged  = (old_row & ~wmask) | (wdata & wmask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) rows[i] <= '0;
      end else if (we && int'(waddr) < DEPTH) begin
         rows[waddr] <= merged;
      end
   end

   assign rdata_a = (int'(raddr_a) < DEPTH) ? rows[raddr_a] : '0;
   assign rdata_b = (int'(raddr_b) < DEPTH) ? rows[raddr_b] : '0;

   logic [ADDR_W-1:0] last_waddr;
   always_ff @(posedge clk) last_waddr <= waddr;

   // R6
   word_write_chk : assert property (@(posedge clk) disable iff (!rst_n)
      we && wsize[1] |=> rows[last_waddr] == $past(wdata));

   // R7
   byte_upper_kept_chk : assert property (@(posedge clk) disable iff (!rst_n)
      we && MASKED && wsize == SZ_BYTE
      |=> rows[last_waddr][DATA_W-1:8] == $past(old_row[DATA_W-1:8]));

   // R7
   half_upper_kept_chk : assert property (@(posedge clk) disable iff (!rst_n)
      we && MASKED && wsize == SZ_HALF
      |=> rows[last_waddr][DATA_W-1:16] == $past(old_row[DATA_W-1:16]));

   // R6
   waddr_range_chk : assert property (@(posedge clk) disable iff (!rst_n)
      we |-> int'(waddr) < DEPTH);

endmodule

// File: rtl/rb_status.sv
module rb_status
   import regbank_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpsr_we,
   input  logic [DATA_W-1:0] cpsr_wdata,
   input  logic              spsr_we,
   input  logic [DATA_W-1:0] spsr_wdata,
   input  logic              exc_en,
   input  logic [MODE_W-1:0] exc_mode,
   output logic [DATA_W-1:0] cpsr,
   output logic [DATA_W-1:0] spsr_cur,
   output logic [MODE_W-1:0] cur_mode,
   output logic              cur_priv
);

   initial begin
      stat_w_chk : assert (DATA_W > MODE_W)
         else $error("status word must hold the mode field");
   end

   logic [NUM_EXC-1:0][DATA_W-1:0] spsr_q;
   bank_e cur_bank;
   bank_e exc_bank;
   logic  exc_ok;

   always_comb begin
      cur_mode = cpsr[MODE_W-1:0];
      cur_bank = bank_of(cur_mode);
      cur_priv = is_priv(cur_mode);
      exc_bank = bank_of(exc_mode);
      exc_ok   = exc_en && is_exc(exc_mode);
      spsr_cur = (cur_bank != BK_USR) ? spsr_q[int'(cur_bank) - 1] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpsr   <= DATA_W'(M_SVC);
         spsr_q <= '0;
      end else if (exc_ok) begin
         spsr_q[int'(exc_bank) - 1] <= cpsr;
         cpsr <= {cpsr[DATA_W-1:MODE_W], exc_mode};
      end else begin
         if (cpsr_we) begin
            cpsr <= cur_priv ? cpsr_wdata
                             : {cpsr_wdata[DATA_W-1:MODE_W], cpsr[MODE_W-1:0]};
         end
         if (spsr_we && cur_bank != BK_USR) begin
            spsr_q[int'(cur_bank) - 1] <= spsr_wdata;
         end
      end
   end

   // R9
   exc_entry_chk : assert property (@(posedge clk) disable iff (!rst_n)
      exc_ok |=> cpsr[MODE_W-1:0] == $past(exc_mode) && spsr_cur == $past(cpsr)
                 && cpsr[DATA_W-1:MODE_W] == $past(cpsr[DATA_W-1:MODE_W]));

   // R9
   exc_bad_code_chk : assert property (@(posedge clk) disable iff (!rst_n)
      exc_en && !is_exc(exc_mode) && !cpsr_we && !spsr_we |=> $stable(cpsr) && $stable(spsr_q));

   // R12
   user_mode_lock_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !cur_priv && !exc_ok |=> cpsr[MODE_W-1:0] == $past(cpsr[MODE_W-1:0]));

   // R10
   spsr_no_bank_chk : assert property (@(posedge clk) disable iff (!rst_n)
      cur_bank == BK_USR && !exc_ok |=> $stable(spsr_q));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import regbank_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit MASKED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        rd_a_idx,
   input  logic              rd_a_use_alt,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [3:0]        rd_b_idx,
   input  logic              rd_b_use_alt,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic [4:0]        alt_mode,
   input  logic              wr_en,
   input  logic [3:0]        wr_idx,
   input  logic              wr_use_alt,
   input  logic [1:0]        wr_size,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              link_en,
   input  logic [DATA_W-1:0] link_addr,
   input  logic              cpsr_wr_en,
   input  logic [DATA_W-1:0] cpsr_wr_data,
   input  logic              spsr_wr_en,
   input  logic [DATA_W-1:0] spsr_wr_data,
   input  logic              exc_en,
   input  logic [4:0]        exc_mode,
   output logic [DATA_W-1:0] cpsr_out,
   output logic [DATA_W-1:0] spsr_out
);

   localparam int NUM_PORTS = 3;
   localparam int P_RA      = 0;
   localparam int P_RB      = 1;
   localparam int P_WR      = 2;
   localparam int ADDR_W    = $clog2(NUM_PHYS);

   logic [MODE_W-1:0] cur_mode;
   logic              cur_priv;

   rb_status #(.DATA_W(DATA_W)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpsr_we    (cpsr_wr_en),
      .cpsr_wdata (cpsr_wr_data),
      .spsr_we    (spsr_wr_en),
      .spsr_wdata (spsr_wr_data),
      .exc_en     (exc_en),
      .exc_mode   (exc_mode),
      .cpsr       (cpsr_out),
      .spsr_cur   (spsr_out),
      .cur_mode   (cur_mode),
      .cur_priv   (cur_priv)
   );

   logic [IDX_W-1:0]  port_idx  [NUM_PORTS];
   logic              port_alt  [NUM_PORTS];
   logic [MODE_W-1:0] port_mode [NUM_PORTS];
   logic [ADDR_W-1:0] port_phys [NUM_PORTS];

   assign port_idx[P_RA] = rd_a_idx;
   assign port_idx[P_RB] = rd_b_idx;
   assign port_idx[P_WR] = wr_idx;
   assign port_alt[P_RA] = rd_a_use_alt;
   assign port_alt[P_RB] = rd_b_use_alt;
   assign port_alt[P_WR] = wr_use_alt;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         assign port_mode[p] = (port_alt[p] && cur_priv) ? alt_mode : cur_mode;
         rb_map #(.ADDR_W(ADDR_W)) u_map (
            .mode (port_mode[p]),
            .idx  (port_idx[p]),
            .phys (port_phys[p])
         );
      end
   endgenerate

   logic [ADDR_W-1:0] lr_phys;
   rb_map #(.ADDR_W(ADDR_W)) u_lr_map (
      .mode (cur_mode),
      .idx  (IDX_W'(IDX_LR)),
      .phys (lr_phys)
   );

   logic              arr_we;
   logic [ADDR_W-1:0] arr_waddr;
   logic [1:0]        arr_wsize;
   logic [DATA_W-1:0] arr_wdata;

   always_comb begin
      if (link_en) begin
         arr_we    = 1'b1;
         arr_waddr = lr_phys;
         arr_wsize = SZ_WORD;
         arr_wdata = link_addr;
      end else begin
         arr_we    = wr_en;
         arr_waddr = port_phys[P_WR];
         arr_wsize = wr_size;
         arr_wdata = wr_data;
      end
   end

   rb_gpr_array #(
      .DATA_W (DATA_W),
      .DEPTH  (NUM_PHYS),
      .MASKED (MASKED)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (arr_we),
      .waddr   (arr_waddr),
      .wsize   (arr_wsize),
      .wdata   (arr_wdata),
      .raddr_a (port_phys[P_RA]),
      .rdata_a (rd_a_data),
      .raddr_b (port_phys[P_RB]),
      .rdata_b (rd_b_data)
   );

   // R5
   pc_shared_chk : assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_a_idx) == IDX_PC && int'(rd_b_idx) == IDX_PC |-> rd_a_data == rd_b_data);

   // R2
   low_shared_chk : assert property (@(posedge clk) disable iff (!rst_n)
      rd_a_idx == rd_b_idx && int'(rd_a_idx) < LOW_CNT |-> rd_a_data == rd_b_data);

   // R11
   unpriv_alt_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !cur_priv && rd_a_idx == rd_b_idx && !rd_b_use_alt |-> rd_a_data == rd_b_data);

   // R8
   link_write_chk : assert property (@(posedge clk) disable iff (!rst_n)
      link_en |=> !($stable(cur_mode) && int'(rd_a_idx) == IDX_LR && !rd_a_use_alt)
                  || rd_a_data == $past(link_addr));

endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    rd_a_idx = '0;
   logic          rd_a_use_alt = 1'b0;
   logic [DW-1:0] rd_a_data;
   logic [3:0]    rd_b_idx = '0;
   logic          rd_b_use_alt = 1'b0;
   logic [DW-1:0] rd_b_data;
   logic [4:0]    alt_mode = 5'b10000;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_idx = '0;
   logic          wr_use_alt = 1'b0;
   logic [1:0]    wr_size = 2'b10;
   logic [DW-1:0] wr_data = '0;
   logic          link_en = 1'b0;
   logic [DW-1:0] link_addr = '0;
   logic          cpsr_wr_en = 1'b0;
   logic [DW-1:0] cpsr_wr_data = '0;
   logic          spsr_wr_en = 1'b0;
   logic [DW-1:0] spsr_wr_data = '0;
   logic          exc_en = 1'b0;
   logic [4:0]    exc_mode = '0;
   logic [DW-1:0] cpsr_out;
   logic [DW-1:0] spsr_out;

   localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                          SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                          SYS = 5'b11111;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   banked_regfile #(.DATA_W(DW)) i_banked_regfile (.*);

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] idx, output logic [DW-1:0] val);
      rd_a_idx = idx;
      rd_a_use_alt = 1'b0;
      #0.1;
      val = rd_a_data;
   endtask

   task automatic wr(input logic [3:0] idx, input logic [DW-1:0] d, input logic [1:0] sz);
      wr_en = 1'b1; wr_idx = idx; wr_data = d; wr_size = sz;
      tick();
      wr_en = 1'b0; wr_size = 2'b10;
   endtask

   task automatic set_mode(input logic [4:0] m);
      cpsr_wr_en = 1'b1; cpsr_wr_data = {27'd0, m};
      tick();
      cpsr_wr_en = 1'b0;
   endtask

   task automatic enter_exc(input logic [4:0] m);
      exc_en = 1'b1; exc_mode = m;
      tick();
      exc_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      for (int i = 0; i < 16; i++) begin
         rd(4'(i), v);
         check($sformatf("R1 reg %0d zero", i), v, '0);
      end
      check("R1 cpsr reset", cpsr_out, 32'h0000_0013);
      check("R1 spsr reset", spsr_out, '0);
   endtask

   task automatic t_write_timing();
      logic [DW-1:0] v;
      wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h55AA_55AA; wr_size = 2'b10;
      rd_a_idx = 4'd5;
      #0.1;
      check("R6 same-cycle read old", rd_a_data, '0);
      tick();
      wr_en = 1'b0;
      rd(4'd5, v);
      check("R6 value after edge", v, 32'h55AA_55AA);
   endtask

   task automatic t_sizes();
      logic [DW-1:0] v;
      wr(4'd6, 32'hFFFF_FFFF, 2'b10);
      wr(4'd6, 32'h1234_5678, 2'b00);
      rd(4'd6, v);
      check("R7 byte write", v, 32'hFFFF_FF78);
      wr(4'd6, 32'hABCD_1234, 2'b01);
      rd(4'd6, v);
      check("R7 half write", v, 32'hFFFF_1234);
      wr(4'd6, 32'h0BAD_F00D, 2'b11);
      rd(4'd6, v);
      check("R7 size 11 full word", v, 32'h0BAD_F00D);
   endtask

   task automatic t_low_shared();
      logic [DW-1:0] v;
      wr(4'd3, 32'h3333_3333, 2'b10);
      set_mode(FIQ);
      rd(4'd3, v);
      check("R2 r3 seen in FIQ", v, 32'h3333_3333);
      set_mode(IRQ);
      rd(4'd3, v);
      check("R2 r3 seen in IRQ", v, 32'h3333_3333);
      set_mode(SVC);
   endtask

   task automatic t_fiq_bank();
      logic [DW-1:0] v;
      wr(4'd9, 32'h0909_0909, 2'b10);
      set_mode(FIQ);
      rd(4'd9, v);
      check("R3 FIQ r9 private", v, '0);
      wr(4'd9, 32'hF9F9_F9F9, 2'b10);
      set_mode(IRQ);
      rd(4'd9, v);
      check("R3 IRQ shares r9", v, 32'h0909_0909);
      set_mode(FIQ);
      rd(4'd9, v);
      check("R3 FIQ r9 kept", v, 32'hF9F9_F9F9);
   endtask

   task automatic t_sp_lr();
      logic [DW-1:0] v;
      set_mode(SYS); wr(4'd13, 32'hD0D0_D0D0, 2'b10);
      set_mode(SVC); wr(4'd13, 32'hE0E0_E0E0, 2'b10);
      set_mode(IRQ); wr(4'd13, 32'h1E1E_1E1E, 2'b10);
      set_mode(SYS); rd(4'd13, v);
      check("R4 SYS sp", v, 32'hD0D0_D0D0);
      set_mode(ABT); rd(4'd13, v);
      check("R4 ABT sp private", v, '0);
      set_mode(SVC); rd(4'd13, v);
      check("R4 SVC sp", v, 32'hE0E0_E0E0);
      set_mode(IRQ); rd(4'd13, v);
      check("R4 IRQ sp", v, 32'h1E1E_1E1E);
   endtask

   task automatic t_pc();
      logic [DW-1:0] v;
      set_mode(FIQ);
      wr(4'd15, 32'h0000_1000, 2'b10);
      set_mode(UND);
      rd(4'd15, v);
      check("R5 pc in UND", v, 32'h0000_1000);
      set_mode(SYS);
      rd_b_idx = 4'd15; rd_b_use_alt = 1'b0;
      #0.1;
      check("R5 pc in SYS", rd_b_data, 32'h0000_1000);
   endtask

   task automatic t_link();
      logic [DW-1:0] v;
      set_mode(IRQ);
      link_en = 1'b1; link_addr = 32'h0000_2004;
      wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'h0000_0BAD;
      tick();
      link_en = 1'b0; wr_en = 1'b0;
      rd(4'd14, v);
      check("R8 link lands in IRQ lr", v, 32'h0000_2004);
      rd(4'd2, v);
      check("R8 wr ignored during link", v, '0);
      set_mode(SVC);
      rd(4'd14, v);
      check("R8 SVC lr untouched", v, '0);
   endtask

   task automatic t_alt();
      logic [DW-1:0] v;
      rd_a_idx = 4'd9; rd_a_use_alt = 1'b1; alt_mode = FIQ;
      rd_b_idx = 4'd14; rd_b_use_alt = 1'b1;
      #0.1;
      check("R11 alt read FIQ r9", rd_a_data, 32'hF9F9_F9F9);
      alt_mode = IRQ;
      #0.1;
      check("R11 alt read IRQ lr", rd_b_data, 32'h0000_2004);
      rd_a_use_alt = 1'b0; rd_b_use_alt = 1'b0;
      alt_mode = ABT; wr_use_alt = 1'b1;
      wr(4'd13, 32'hAB00_0013, 2'b10);
      wr_use_alt = 1'b0;
      rd(4'd13, v);
      check("R11 SVC sp not hit", v, 32'hE0E0_E0E0);
      set_mode(ABT);
      rd(4'd13, v);
      check("R11 alt write reached ABT sp", v, 32'hAB00_0013);
   endtask

   task automatic t_status();
      logic [DW-1:0] v;
      cpsr_wr_en = 1'b1; cpsr_wr_data = 32'hF000_001F;
      tick();
      cpsr_wr_en = 1'b0;
      check("R10 SYS spsr zero", spsr_out, '0);
      enter_exc(IRQ);
      check("R9 cpsr after entry", cpsr_out, 32'hF000_0012);
      check("R9 saved status", spsr_out, 32'hF000_001F);
      enter_exc(USR);
      check("R9 bad code cpsr kept", cpsr_out, 32'hF000_0012);
      check("R9 bad code spsr kept", spsr_out, 32'hF000_001F);
      spsr_wr_en = 1'b1; spsr_wr_data = 32'h1234_5678;
      tick();
      spsr_wr_en = 1'b0;
      check("R10 spsr write in IRQ", spsr_out, 32'h1234_5678);
      set_mode(SYS);
      spsr_wr_en = 1'b1; spsr_wr_data = 32'hDEAD_BEEF;
      tick();
      spsr_wr_en = 1'b0;
      check("R10 SYS spsr write ignored", spsr_out, '0);
      set_mode(IRQ);
      check("R10 IRQ spsr unchanged", spsr_out, 32'h1234_5678);
      rd(4'd0, v);
   endtask

   task automatic t_user();
      logic [DW-1:0] v;
      set_mode(USR);
      cpsr_wr_en = 1'b1; cpsr_wr_data = 32'h8000_001F;
      tick();
      cpsr_wr_en = 1'b0;
      check("R12 user keeps mode bits", cpsr_out, 32'h8000_0010);
      rd(4'd13, v);
      check("R4 USR shares SYS sp", v, 32'hD0D0_D0D0);
      rd_a_idx = 4'd9; rd_a_use_alt = 1'b1; alt_mode = FIQ;
      #0.1;
      check("R11 user alt read ignored", rd_a_data, 32'h0909_0909);
      rd_a_use_alt = 1'b0;
      alt_mode = SVC; wr_use_alt = 1'b1;
      wr(4'd13, 32'h0000_0077, 2'b10);
      wr_use_alt = 1'b0;
      rd(4'd13, v);
      check("R11 user alt write to own sp", v, 32'h0000_0077);
      enter_exc(SVC);
      check("R9 entry from user cpsr", cpsr_out, 32'h8000_0013);
      check("R9 entry from user spsr", spsr_out, 32'h8000_0010);
      rd(4'd13, v);
      check("R11 SVC sp untouched", v, 32'hE0E0_E0E0);
   endtask

   task automatic t_unknown();
      logic [DW-1:0] v;
      set_mode(5'b10101);
      rd(4'd13, v);
      check("R13 unknown maps as user", v, 32'h0000_0077);
      check("R13 unknown spsr zero", spsr_out, '0);
      rd_a_idx = 4'd9; rd_a_use_alt = 1'b1; alt_mode = FIQ;
      #0.1;
      check("R13 unknown unprivileged alt", rd_a_data, 32'h0909_0909);
      rd_a_use_alt = 1'b0;
      set_mode(SVC);
      check("R13 unknown cannot change mode", cpsr_out, 32'h0000_0015);
      enter_exc(SVC);
      check("R9 recover by entry", cpsr_out, 32'h0000_0013);
      check("R9 saved unknown status", spsr_out, 32'h0000_0015);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_write_timing();
      t_sizes();
      t_low_shared();
      t_fiq_bank();
      t_sp_lr();
      t_pc();
      t_link();
      t_alt();
      t_status();
      t_user();
      t_unknown();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule